// File: doc/BRIEF.md
# Card Status Change Interrupt Unit

This block watches the status pins of four removable-card sockets, arranged as two controllers of two sockets each, and turns pin activity into latched status-change bits, steered interrupt lines and a per-socket queue of insertion and removal events. Each socket has two card-detect pins, plus ready, battery-warning, battery-dead and general-purpose input pins. A host reaches every per-socket register through one flat read/write port.

Card presence is the AND of both detect pins. It is synchronised and debounced before use. A logical "attached" flag suppresses duplicate events. An insertion event is queued only while the card is not attached, and the flag sets when the host dequeues that insertion. When presence falls while the card is attached, the hardware zeroes the socket's power register and its interrupt/reset register, queues a removal event and clears the flag, all on the same edge.

Top module: `cardStatusIrq`

## Requirements
- R1: After reset every socket reads status 0, configuration 0, power 0, interrupt/reset 0, event register 0 and state 0. All interrupt lines and irqAny are low.
- R2: Each level pin (ready, battery warning, battery dead, general-purpose input) passes through two synchroniser flops. On a change in either direction, the pin sets its status bit on the third rising edge after the pin changes, but only if its enable bit in the configuration register is set. Status bit positions are: 0 battery dead, 1 battery warning, 2 ready, 3 card detect, 4 general-purpose input. Bits 7..5 read 0.
- R3: The two detect pins of socket s are detPins[2s+1:2s], and the card counts as present only when both are 1. The presence value changes only after the combined value has differed from it on DEBOUNCE_CYCLES consecutive edges. A shorter pulse, or a single detect pin alone, never changes presence.
- R4: A read of the status register returns the latched bits and clears them on the same edge. A change that latches on that same edge is kept for the next read.
- R5: Configuration bits 4..0 enable the five sources, at the same positions as the status bits. Bits 7..5 select one of eight interrupt lines. irqLines[n] is high while some socket whose selection is n holds a nonzero status. irqAny is the OR over all sockets.
- R6: When presence rises and the card is not attached, an insertion event is queued. When presence rises while the card is attached, no event is queued.
- R7: When presence falls while the card is attached, the power and interrupt/reset registers become 0 on the same edge, and this overrides a host write on that edge. A removal event is queued and the attached flag clears.
- R8: When presence falls while the card is not attached, no event is queued and the power register keeps its value.
- R9: The event register reads {overflow in bit 2, valid in bit 1, type in bit 0}, where type 1 is insertion and 0 is removal. Reading it dequeues the head. Dequeuing an insertion sets the attached flag. The state register reads attached in bit 1 and present in bit 0.
- R10: Each socket's event queue holds EVT_DEPTH entries. A push into a full queue with no pop on that edge is dropped and sets a sticky overflow bit. Any read of the event register clears the overflow bit.
- R11: hostAddr is {socket, register[2:0]}, with registers 0 status, 1 configuration, 2 power, 3 interrupt/reset, 4 event and 5 state. Writes to 0, 4 and 5 have no effect. An access to one socket leaves the other sockets unchanged.
- R12: After the configuration is written to 0 and the status register is read, later pin activity leaves the socket's status at 0 and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| detPins | input | 2*SOCKETS | Card-detect pin pairs, 1 = seated |
| rdyPins | input | SOCKETS | Card ready pins |
| warnPins | input | SOCKETS | Battery-warning pins |
| deadPins | input | SOCKETS | Battery-dead pins |
| gpiPins | input | SOCKETS | General-purpose input pins |
| hostRd | input | 1 | Read strobe; data is valid in the same cycle, side effects take place at the edge |
| hostWr | input | 1 | Write strobe |
| hostAddr | input | SOCK_W+3 | {socket, register} |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Read data, 0 when no read is active |
| irqLines | output | 8 | Steered interrupt lines |
| irqAny | output | 1 | OR of all socket interrupts |
| powerOut | output | 8*SOCKETS | Power register of each socket |
| sockResetOut | output | 8*SOCKETS | Interrupt/reset register of each socket |

## Verification
The assertions assume that pins hold at 0 through reset, so that no spurious change appears when reset releases. They also assume the host performs at most one register access per cycle. The stimulus drives every pin and host signal only at falling edges, and holds pins low during reset. Detect glitches last fewer cycles than the debounce window, and each real detect change is held well beyond that window, so every presence change is clean. Events are dequeued only while no detect change is in flight, which keeps the pop-versus-removal ordering on the same edge out of the stimulus.

// File: rtl/cscPkg.sv
package cscPkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;
  localparam int CHG_W = 5;

  localparam logic [2:0] RA_STATUS = 3'd0;
  localparam logic [2:0] RA_CFG    = 3'd1;
  localparam logic [2:0] RA_POWER  = 3'd2;
  localparam logic [2:0] RA_INTRST = 3'd3;
  localparam logic [2:0] RA_EVENT  = 3'd4;
  localparam logic [2:0] RA_STATE  = 3'd5;

  localparam int BIT_DEAD = 0;
  localparam int BIT_WARN = 1;
  localparam int BIT_RDY  = 2;
  localparam int BIT_CD   = 3;
  localparam int BIT_GPI  = 4;

  typedef struct packed {
    logic cfgWr;
    logic pwrWr;
    logic rstWr;
    logic statClr;
    logic evtPop;
    logic evtClrOvf;
    logic evtPush;
    logic evtType;
    logic forceOff;
  } cscStrobes_t;
endpackage

// File: rtl/cscInputCond.sv
module cscInputCond #(
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] detPin,
  input  logic [3:0] lvlPin,
  output logic       present,
  output logic       cdChg,
  output logic [3:0] lvlChg
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [1:0] detMeta, detSync;
  logic [3:0] lvlMeta, lvlSync, lvlPrev;
  logic [CNT_W-1:0] stableCnt;
  logic rawPresent, flip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detMeta <= '0;
      detSync <= '0;
      lvlMeta <= '0;
      lvlSync <= '0;
      lvlPrev <= '0;
    end else begin
      detMeta <= detPin;
      detSync <= detMeta;
      lvlMeta <= lvlPin;
      lvlSync <= lvlMeta;
      lvlPrev <= lvlSync;
    end
  end

  assign lvlChg     = lvlSync ^ lvlPrev;
  assign rawPresent = &detSync;
  assign flip       = (rawPresent != present) && (stableCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      present   <= 1'b0;
      stableCnt <= '0;
      cdChg     <= 1'b0;
    end else begin
      cdChg <= flip;
      if (rawPresent == present) begin
        stableCnt <= '0;
      end else if (flip) begin
        present   <= rawPresent;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end

  // R3
  debounce_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(present) |-> present == $past(rawPresent));
endmodule

// File: rtl/cscControl.sv
module cscControl
  import cscPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic        sockHit,
  input  logic [2:0]  regSel,
  input  logic        present,
  input  logic        cdChg,
  input  logic        evtValid,
  input  logic        evtHeadType,
  output cscStrobes_t stb,
  output logic        attached
);
  logic rdAcc, wrAcc, evtRead, removal, insertion;

  assign rdAcc     = hostRd && sockHit;
  assign wrAcc     = hostWr && sockHit;
  assign evtRead   = rdAcc && (regSel == RA_EVENT);
  assign removal   = cdChg && !present && attached;
  assign insertion = cdChg && present && !attached;

  always_comb begin
    stb           = '0;
    stb.cfgWr     = wrAcc && (regSel == RA_CFG);
    stb.pwrWr     = wrAcc && (regSel == RA_POWER);
    stb.rstWr     = wrAcc && (regSel == RA_INTRST);
    stb.statClr   = rdAcc && (regSel == RA_STATUS);
    stb.evtPop    = evtRead && evtValid;
    stb.evtClrOvf = evtRead;
    stb.evtPush   = removal || insertion;
    stb.evtType   = insertion;
    stb.forceOff  = removal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attached <= 1'b0;
    end else if (removal) begin
      attached <= 1'b0;
    end else if (stb.evtPop && evtHeadType) begin
      attached <= 1'b1;
    end
  end

  // R9
  attach_on_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(attached) |-> $past(stb.evtPop));

  // R7
  detach_on_removal_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceOff |=> !attached);
endmodule

// File: rtl/cscDatapath.sv
module cscDatapath
  import cscPkg::*;
#(
  parameter int EVT_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cscStrobes_t      stb,
  input  logic [CHG_W-1:0] chgVec,
  input  logic [REG_W-1:0] wrData,
  input  logic [2:0]       regSel,
  input  logic             attached,
  input  logic             present,
  output logic [REG_W-1:0] readData,
  output logic [REG_W-1:0] cfgOut,
  output logic [REG_W-1:0] pwrOut,
  output logic [REG_W-1:0] rstOut,
  output logic             statusAny,
  output logic             evtValid,
  output logic             evtHeadType
);
  localparam int PTR_W = (EVT_DEPTH > 1) ? $clog2(EVT_DEPTH) : 1;
  localparam int CNT_W = $clog2(EVT_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(EVT_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(EVT_DEPTH - 1);

  logic [CHG_W-1:0]     statusReg;
  logic [REG_W-1:0]     cfgReg, pwrReg, rstReg;
  logic [EVT_DEPTH-1:0] evtMem;
  logic [PTR_W-1:0]     rdPtr, wrPtr;
  logic [CNT_W-1:0]     evtCount;
  logic                 evtOvf, evtFull, pushOk, pushDrop;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      cfgReg    <= '0;
      pwrReg    <= '0;
      rstReg    <= '0;
    end else begin
      statusReg <= (stb.statClr ? '0 : statusReg) | (chgVec & cfgReg[CHG_W-1:0]);
      if (stb.cfgWr) cfgReg <= wrData;
      if (stb.forceOff)   pwrReg <= '0;
      else if (stb.pwrWr) pwrReg <= wrData;
      if (stb.forceOff)   rstReg <= '0;
      else if (stb.rstWr) rstReg <= wrData;
    end
  end

  assign evtFull  = (evtCount == FULL_CNT);
  assign pushOk   = stb.evtPush && (!evtFull || stb.evtPop);
  assign pushDrop = stb.evtPush && evtFull && !stb.evtPop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtMem   <= '0;
      rdPtr    <= '0;
      wrPtr    <= '0;
      evtCount <= '0;
      evtOvf   <= 1'b0;
    end else begin
      if (pushOk) begin
        evtMem[wrPtr] <= stb.evtType;
        wrPtr         <= bumpPtr(wrPtr);
      end
      if (stb.evtPop) rdPtr <= bumpPtr(rdPtr);
      if (pushOk && !stb.evtPop)      evtCount <= evtCount + 1'b1;
      else if (!pushOk && stb.evtPop) evtCount <= evtCount - 1'b1;
      if (pushDrop)           evtOvf <= 1'b1;
      else if (stb.evtClrOvf) evtOvf <= 1'b0;
    end
  end

  assign evtValid    = (evtCount != '0);
  assign evtHeadType = evtValid && evtMem[rdPtr];
  assign cfgOut      = cfgReg;
  assign pwrOut      = pwrReg;
  assign rstOut      = rstReg;
  assign statusAny   = |statusReg;

  always_comb begin
    unique case (regSel)
      RA_STATUS: readData = {{(REG_W-CHG_W){1'b0}}, statusReg};
      RA_CFG:    readData = cfgReg;
      RA_POWER:  readData = pwrReg;
      RA_INTRST: readData = rstReg;
      RA_EVENT:  readData = {{(REG_W-3){1'b0}}, evtOvf, evtValid, evtHeadType};
      RA_STATE:  readData = {{(REG_W-2){1'b0}}, attached, present};
      default:   readData = '0;
    endcase
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtCount <= FULL_CNT);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtOvf) |-> $past(stb.evtPush && evtFull && !stb.evtPop));

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.statClr && chgVec == '0 |=> statusReg == '0);

  // R7
  force_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceOff |=> pwrReg == '0 && rstReg == '0);
endmodule

// File: rtl/cardStatusIrq.sv
module cardStatusIrq
  import cscPkg::*;
#(
  parameter int SOCKETS         = 4,
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int EVT_DEPTH       = 4,
  localparam int SOCK_W    = (SOCKETS > 1) ? $clog2(SOCKETS) : 1,
  localparam int ADDR_W    = SOCK_W + 3,
  localparam int IRQ_LINES = 1 << SEL_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2*SOCKETS-1:0]     detPins,
  input  logic [SOCKETS-1:0]       rdyPins,
  input  logic [SOCKETS-1:0]       warnPins,
  input  logic [SOCKETS-1:0]       deadPins,
  input  logic [SOCKETS-1:0]       gpiPins,
  input  logic                     hostRd,
  input  logic                     hostWr,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [REG_W-1:0]         hostWrData,
  output logic [REG_W-1:0]         hostRdData,
  output logic [IRQ_LINES-1:0]     irqLines,
  output logic                     irqAny,
  output logic [REG_W*SOCKETS-1:0] powerOut,
  output logic [REG_W*SOCKETS-1:0] sockResetOut
);
  logic [SOCK_W-1:0] sockSel;
  logic [2:0]        regSel;
  logic [REG_W-1:0]  readVal [SOCKETS];
  logic [SEL_W-1:0]  lineSel [SOCKETS];
  logic [SOCKETS-1:0] sockIrq;

  assign sockSel = hostAddr[ADDR_W-1:3];
  assign regSel  = hostAddr[2:0];

  for (genvar s = 0; s < SOCKETS; s++) begin : g_sock
    logic        present, cdChg, attached, evtValid, evtHeadType, sockHit;
    logic [3:0]  lvlChg;
    logic [CHG_W-1:0] chgVec;
    logic [REG_W-1:0] cfgVal;
    cscStrobes_t stb;

    assign sockHit = (sockSel == SOCK_W'(s));

    cscInputCond #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_cond (
      .clk(clk), .rstN(rstN),
      .detPin(detPins[2*s +: 2]),
      .lvlPin({gpiPins[s], rdyPins[s], warnPins[s], deadPins[s]}),
      .present(present), .cdChg(cdChg), .lvlChg(lvlChg)
    );

    always_comb begin
      chgVec           = '0;
      chgVec[BIT_DEAD] = lvlChg[0];
      chgVec[BIT_WARN] = lvlChg[1];
      chgVec[BIT_RDY]  = lvlChg[2];
      chgVec[BIT_CD]   = cdChg;
      chgVec[BIT_GPI]  = lvlChg[3];
    end

    cscControl u_ctrl (
      .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
      .sockHit(sockHit), .regSel(regSel), .present(present), .cdChg(cdChg),
      .evtValid(evtValid), .evtHeadType(evtHeadType),
      .stb(stb), .attached(attached)
    );

    cscDatapath #(.EVT_DEPTH(EVT_DEPTH)) u_dp (
      .clk(clk), .rstN(rstN), .stb(stb), .chgVec(chgVec),
      .wrData(hostWrData), .regSel(regSel), .attached(attached),
      .present(present), .readData(readVal[s]), .cfgOut(cfgVal),
      .pwrOut(powerOut[REG_W*s +: REG_W]),
      .rstOut(sockResetOut[REG_W*s +: REG_W]),
      .statusAny(sockIrq[s]), .evtValid(evtValid), .evtHeadType(evtHeadType)
    );

    assign lineSel[s] = cfgVal[REG_W-1 -: SEL_W];
  end

  always_comb begin
    hostRdData = '0;
    if (hostRd) begin
      for (int s = 0; s < SOCKETS; s++) begin
        if (sockSel == SOCK_W'(s)) hostRdData = readVal[s];
      end
    end
  end

  always_comb begin
    irqLines = '0;
    for (int s = 0; s < SOCKETS; s++) begin
      if (sockIrq[s]) irqLines[lineSel[s]] = 1'b1;
    end
  end

  assign irqAny = |sockIrq;

  // R5
  irq_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (|irqLines));
endmodule

// File: tb/cardStatusIrq_test.sv
module cardStatusIrq_test;
  localparam int NS = 4;
  localparam int DEB = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic [2*NS-1:0] detPins;
  logic [NS-1:0] rdyPins, warnPins, deadPins, gpiPins;
  logic hostRd, hostWr;
  logic [4:0] hostAddr;
  logic [7:0] hostWrData;
  logic [7:0] hostRdData;
  logic [7:0] irqLines;
  logic irqAny;
  logic [8*NS-1:0] powerOut, sockResetOut;

  cardStatusIrq #(.SOCKETS(NS), .DEBOUNCE_CYCLES(DEB), .EVT_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .detPins(detPins), .rdyPins(rdyPins),
    .warnPins(warnPins), .deadPins(deadPins), .gpiPins(gpiPins),
    .hostRd(hostRd), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irqLines(irqLines),
    .irqAny(irqAny), .powerOut(powerOut), .sockResetOut(sockResetOut)
  );

  int nChecks = 0;
  int nFail = 0;

  // behavioural reference state
  logic [1:0] mS1D [NS], mS2D [NS];
  logic [3:0] mS1L [NS], mS2L [NS], mPrevL [NS];
  bit mDb [NS], mCdChg [NS], mOvf [NS], mAtt [NS];
  int mCnt [NS];
  logic [4:0] mStat [NS];
  logic [7:0] mCfg [NS], mPwr [NS], mRst [NS];
  int mQ [NS][DEPTH];
  int mQn [NS];

  bit expValid = 0;
  logic [7:0] expVal;
  string expTag;

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic resetModel();
    for (int s = 0; s < NS; s++) begin
      mS1D[s] = 0; mS2D[s] = 0; mS1L[s] = 0; mS2L[s] = 0; mPrevL[s] = 0;
      mDb[s] = 0; mCdChg[s] = 0; mOvf[s] = 0; mAtt[s] = 0; mCnt[s] = 0;
      mStat[s] = 0; mCfg[s] = 0; mPwr[s] = 0; mRst[s] = 0; mQn[s] = 0;
    end
  endtask

  function automatic logic [7:0] modelRead(input int s, input int r);
    case (r)
      0: return {3'b0, mStat[s]};
      1: return mCfg[s];
      2: return mPwr[s];
      3: return mRst[s];
      4: return {5'b0, mOvf[s], mQn[s] > 0, (mQn[s] > 0) ? mQ[s][0] == 1 : 1'b0};
      5: return {6'b0, mAtt[s], mDb[s]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] modelIrq();
    logic [7:0] v = 8'h00;
    for (int s = 0; s < NS; s++) if (mStat[s] != 0) v[mCfg[s][7:5]] = 1'b1;
    return v;
  endfunction

  task automatic modelStep();
    logic [3:0] lchg;
    logic [4:0] chg, nstat;
    bit rawP, flip, hit, rd, wr, rem, ins, evRd, pop, popIns, ovfNew;
    int r;
    for (int s = 0; s < NS; s++) begin
      lchg = mS2L[s] ^ mPrevL[s];
      rawP = (mS2D[s] == 2'b11);
      flip = (rawP != mDb[s]) && (mCnt[s] == DEB - 1);
      chg = {lchg[3], mCdChg[s], lchg[2], lchg[1], lchg[0]};
      hit = (int'(hostAddr[4:3]) == s);
      rd = hostRd && hit;
      wr = hostWr && hit;
      r = int'(hostAddr[2:0]);
      rem = mCdChg[s] && !mDb[s] && mAtt[s];
      ins = mCdChg[s] && mDb[s] && !mAtt[s];
      evRd = rd && (r == 4);
      pop = evRd && (mQn[s] > 0);
      popIns = pop && (mQ[s][0] == 1);
      ovfNew = 0;
      nstat = ((rd && r == 0) ? 5'b0 : mStat[s]) | (chg & mCfg[s][4:0]);
      if (wr && r == 1) mCfg[s] = hostWrData;
      if (rem) mPwr[s] = 0; else if (wr && r == 2) mPwr[s] = hostWrData;
      if (rem) mRst[s] = 0; else if (wr && r == 3) mRst[s] = hostWrData;
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) mQ[s][i] = mQ[s][i+1];
        mQn[s]--;
      end
      if (rem || ins) begin
        if (mQn[s] < DEPTH) begin
          mQ[s][mQn[s]] = ins ? 1 : 0;
          mQn[s]++;
        end else ovfNew = 1;
      end
      if (ovfNew) mOvf[s] = 1; else if (evRd) mOvf[s] = 0;
      if (rem) mAtt[s] = 0; else if (popIns) mAtt[s] = 1;
      mStat[s] = nstat;
      if (rawP == mDb[s]) mCnt[s] = 0;
      else if (flip) begin mDb[s] = rawP; mCnt[s] = 0; end
      else mCnt[s]++;
      mCdChg[s] = flip;
      mPrevL[s] = mS2L[s];
      mS2L[s] = mS1L[s];
      mS2D[s] = mS1D[s];
      mS1L[s] = {gpiPins[s], rdyPins[s], warnPins[s], deadPins[s]};
      mS1D[s] = detPins[2*s +: 2];
    end
  endtask

  // one clock: inputs are already driven at the falling edge
  task automatic cycle();
    int hs, hr;
    #1;
    checkEq(irqLines, modelIrq(), "R5 irqLines");
    checkEq(irqAny, modelIrq() != 0, "R5 irqAny");
    for (int s = 0; s < NS; s++) begin
      checkEq(powerOut[8*s +: 8], mPwr[s], "R7 powerOut");
      checkEq(sockResetOut[8*s +: 8], mRst[s], "R7 sockResetOut");
    end
    if (hostRd) begin
      hs = int'(hostAddr[4:3]);
      hr = int'(hostAddr[2:0]);
      checkEq(hostRdData, modelRead(hs, hr),
              hr == 0 ? "R4 model read" : (hr >= 4 ? "R9 model read" : "R11 model read"));
    end
    if (expValid) checkEq(hostRdData, expVal, expTag);
    expValid = 0;
    if (!rstN) resetModel(); else modelStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) cycle();
  endtask

  task automatic wrReg(input int s, input int r, input logic [7:0] d);
    hostWr = 1; hostAddr = {2'(s), 3'(r)}; hostWrData = d;
    cycle();
    hostWr = 0;
  endtask

  task automatic rdAny(input int s, input int r);
    hostRd = 1; hostAddr = {2'(s), 3'(r)};
    cycle();
    hostRd = 0;
  endtask

  task automatic rdExp(input int s, input int r, input logic [7:0] e, input string tag);
    hostRd = 1; hostAddr = {2'(s), 3'(r)};
    expValid = 1; expVal = e; expTag = tag;
    cycle();
    hostRd = 0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; detPins = 0; rdyPins = 0; warnPins = 0; deadPins = 0; gpiPins = 0;
    hostRd = 0; hostWr = 0; hostAddr = 0; hostWrData = 0;
    resetModel();
    @(negedge clk);
    idle(3);
    rstN = 1;

    // R1 reset state
    rdExp(0, 0, 8'h00, "R1 status");
    rdExp(0, 1, 8'h00, "R1 cfg");
    rdExp(0, 4, 8'h00, "R1 event");
    rdExp(0, 5, 8'h00, "R1 state");
    checkEq(irqAny, 0, "R1 irqAny");
    checkEq(powerOut, 0, "R1 powerOut");

    // R2 ready change on socket 0, line 3
    wrReg(0, 1, 8'h7F);
    rdyPins[0] = 1;
    idle(5);
    checkEq(irqLines, 8'h08, "R5 line 3");
    rdExp(0, 0, 8'h04, "R2 ready bit");
    rdExp(0, 0, 8'h00, "R4 cleared");

    // R2 disabled source on socket 1
    wrReg(1, 1, 8'h21);
    warnPins[1] = 1;
    idle(5);
    rdExp(1, 0, 8'h00, "R2 disabled warn");
    deadPins[1] = 1;
    idle(5);
    rdExp(1, 0, 8'h01, "R2 dead bit");

    // R4 change latching on the read edge
    gpiPins[0] = 1;
    cycle();
    cycle();
    rdExp(0, 0, 8'h00, "R4 same-cycle read");
    rdExp(0, 0, 8'h10, "R4 kept change");

    // R3 glitch, single pin, then real insertion
    detPins[1:0] = 2'b11;
    cycle();
    cycle();
    detPins[1:0] = 2'b00;
    idle(10);
    rdExp(0, 5, 8'h00, "R3 glitch");
    detPins[1:0] = 2'b01;
    idle(10);
    rdExp(0, 5, 8'h00, "R3 one pin");
    detPins[1:0] = 2'b11;
    idle(10);
    rdExp(0, 5, 8'h01, "R3 present");
    rdExp(0, 4, 8'h03, "R6 insertion");
    rdExp(0, 5, 8'h03, "R9 attached");

    // R7 removal while attached
    wrReg(0, 2, 8'h55);
    wrReg(0, 3, 8'hAA);
    checkEq(powerOut[7:0], 8'h55, "R11 power write");
    detPins[1:0] = 2'b00;
    idle(10);
    checkEq(powerOut[7:0], 8'h00, "R7 power off");
    checkEq(sockResetOut[7:0], 8'h00, "R7 reset off");
    rdExp(0, 4, 8'h02, "R7 removal event");
    rdExp(0, 5, 8'h00, "R7 detached");

    // R8 falling presence while not attached
    wrReg(0, 2, 8'h33);
    detPins[1:0] = 2'b11;
    idle(10);
    detPins[1:0] = 2'b00;
    idle(10);
    rdExp(0, 2, 8'h33, "R8 power kept");
    rdExp(0, 4, 8'h03, "R8 only insertion");
    rdExp(0, 4, 8'h00, "R8 queue empty");

    // R6 no duplicate while attached
    detPins[1:0] = 2'b11;
    idle(10);
    rdExp(0, 4, 8'h00, "R6 no duplicate");
    detPins[1:0] = 2'b00;
    idle(10);
    rdExp(0, 4, 8'h02, "R7 removal");

    // R10 overflow
    for (int i = 0; i < 5; i++) begin
      detPins[1:0] = 2'b11;
      idle(10);
      detPins[1:0] = 2'b00;
      idle(10);
    end
    rdExp(0, 4, 8'h07, "R10 overflow");
    for (int i = 0; i < 3; i++) rdExp(0, 4, 8'h03, "R10 remaining");
    rdExp(0, 4, 8'h00, "R10 drained");
    rdExp(0, 5, 8'h02, "R9 state");
    rdAny(0, 0);

    // R11 socket 2, line 5, ignored writes
    wrReg(2, 1, 8'hBF);
    warnPins[2] = 1;
    idle(5);
    checkEq(irqLines, 8'h20, "R5 line 5");
    wrReg(2, 0, 8'hFF);
    wrReg(2, 5, 8'hFF);
    wrReg(2, 4, 8'hFF);
    rdExp(2, 0, 8'h02, "R11 status write ignored");
    rdExp(2, 5, 8'h00, "R11 state write ignored");
    rdExp(2, 4, 8'h00, "R11 event write ignored");
    rdExp(0, 1, 8'h7F, "R11 socket 0 cfg intact");

    // R12 quiet after zero config and status read
    wrReg(2, 1, 8'h00);
    rdAny(2, 0);
    rdyPins[2] = 1; deadPins[2] = 1; gpiPins[2] = 1; warnPins[2] = 0;
    detPins[5:4] = 2'b11;
    idle(12);
    checkEq(irqAny, 0, "R12 no irq");
    rdExp(2, 0, 8'h00, "R12 status quiet");

    summary();
    $finish;
  end
endmodule